// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block derives the bit-level timing of a CAN node from the system clock. A prescaler divides the clock into time quanta. A state machine then walks each nominal bit through a one-quantum synchronisation segment, a first phase segment that ends at the sample point and a second phase segment that ends at the transmit point. At the sample point it pulses `sample_stb` and updates `rx_bit`. At the transmit point it pulses `tx_stb`. The receive line is recessive high and dominant low.

The controller puts the block in its configuration hold by raising `init_mode`. While that input is high, the configuration inputs are copied into shadow registers and the machine rests in `ST_HALT`. When `init_mode` falls, the machine moves to `ST_HUNT` and waits for the start-of-frame edge. That edge hard-synchronises the bit clock. After that, falling edges move the sample and transmit points to follow phase drift between nodes. The controller can optionally ask for a three-sample majority vote, which rejects short spikes.

States and transitions: `init_mode` sends any state to `ST_HALT`. `ST_HALT` goes to `ST_HUNT` once `init_mode` is low. `ST_HUNT` goes to `ST_SYNC` on a falling edge (hard sync). `ST_SYNC` goes to `ST_PH1` on the next quantum tick. `ST_PH1` goes to `ST_PH2` at the tick that ends its (possibly lengthened) length, which is the sample point. `ST_PH2` goes to `ST_SYNC` at the tick that ends its (possibly shortened) length, which is the transmit point.

Top module: `cbt_bit_timer`

## Requirements
- R1: After reset, `sample_stb` and `tx_stb` are 0 and `rx_bit` is 1 (recessive).
- R2: While `init_mode` is 1, no strobe is produced and the configuration inputs are captured. Configuration inputs changed while `init_mode` is 0 have no effect on timing.
- R3: After `init_mode` falls, nothing happens until a falling edge (previous clock's `rx_in` = 1, this clock's `rx_in` = 0). The clock in which that edge is seen is clock 0 of the frame, and the synchronisation quantum starts in the next clock.
- R4: One quantum lasts B = `cfg_brp_m1`+1 clocks. Segment 1 has S1 = `cfg_seg1_m1`+1 quanta (1..16), segment 2 has S2 = `cfg_seg2_m1`+1 quanta (1..8), and the jump width is J = `cfg_sjw_m1`+1 quanta (1..4).
- R5: Without resynchronisation, `sample_stb` is high for exactly one clock, B*(1+S1) clocks after clock 0.
- R6: Without resynchronisation, `tx_stb` is high for exactly one clock, B*(1+S1+S2) clocks after clock 0, and the bit period is B*(1+S1+S2).
- R7: With `cfg_triple` = 0, `rx_bit` takes the value of `rx_in` in the sample-point clock and holds it until the next sample point.
- R8: With `cfg_triple` = 1, `rx_bit` takes the majority of `rx_in` sampled at the ticks ending the last three quanta up to and including the sample point.
- R9: A falling edge in segment 1 lengthens that segment by min(q+1, J) quanta, where q is the index of the current segment-1 quantum counted from 0.
- R10: A falling edge in segment 2 shortens it by min(S2-1-q, J) quanta, where q is the index of the current segment-2 quantum. The segment may end at the tick of the current quantum.
- R11: Rising edges, edges during the synchronisation quantum, edges in the hard-sync bit and any second edge within one bit cause no adjustment.
- R12: When an edge falls in the same clock as the tick that would end segment 1, the lengthening wins and no sample is taken at that tick.
- R13: `sample_stb` and `tx_stb` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_mode | input | 1 | Configuration hold; high keeps the sequencer idle |
| rx_in | input | 1 | Receive line, 1 = recessive, 0 = dominant |
| cfg_brp_m1 | input | BRP_W (6) | Prescaler value minus one |
| cfg_seg1_m1 | input | SEG1_W (4) | Segment 1 length minus one |
| cfg_seg2_m1 | input | SEG2_W (3) | Segment 2 length minus one |
| cfg_sjw_m1 | input | SJW_W (2) | Jump width minus one |
| cfg_triple | input | 1 | Selects three-sample majority |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| rx_bit | output | 1 | Last sampled bit value |
| tx_stb | output | 1 | One-clock pulse at the transmit point |

## Verification
The main coincidence is a falling edge arriving in the same clock as the quantum tick that would end a phase segment. In segment 1 that tick would otherwise fire the sample strobe. In segment 2 it would fire the transmit strobe. The bench provokes this with a one-clock quantum and a falling edge placed exactly on the last segment-1 tick of the second bit. It then checks that the sample strobe appears two quanta later, not on that tick. Early edges are placed on a segment-2 tick and judged by the shifted transmit index and the shifted next sample index.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_HUNT,
        ST_SYNC,
        ST_PH1,
        ST_PH2
    } cbt_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/cbt_tq_prescaler.sv
module cbt_tq_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [BRP_W-1:0] brp_m1,
    output logic             tq_tick
);
    localparam logic [BRP_W-1:0] P_ONE = BRP_W'(1);

    logic [BRP_W-1:0] pcnt;

    assign tq_tick = run && (pcnt == brp_m1);

    // Divider is parked at zero whenever the sequencer is idle, so a hard
    // sync always starts a fresh quantum.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (!run || tq_tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + P_ONE;
    end

    assert_prescale_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pcnt <= brp_m1));

endmodule

// File: rtl/cbt_bit_sampler.sv
module cbt_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_tick,
    input  logic rx_in,
    input  logic triple_en,
    output logic bus_val
);
    import cbt_pkg::*;

    // Line values seen at the two previous quantum ticks.
    logic [1:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist <= 2'b11;
        else if (tq_tick)
            hist <= {hist[0], rx_in};
    end

    always_comb begin
        if (triple_en)
            bus_val = vote3(hist[1], hist[0], rx_in);
        else
            bus_val = rx_in;
    end

endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm #(
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int SJW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_mode,
    input  logic              tq_tick,
    input  logic              fall_edge,
    input  logic              bus_val,
    input  logic [SEG1_W-1:0] seg1_m1,
    input  logic [SEG2_W-1:0] seg2_m1,
    input  logic [SJW_W-1:0]  sjw_m1,
    output logic              run,
    output logic              sample_stb,
    output logic              rx_bit,
    output logic              tx_stb
);
    import cbt_pkg::*;

    localparam int LEN_W = SEG1_W + 2;
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    cbt_state_e       state, state_n;
    logic [LEN_W-1:0] qcnt, len1, len2;
    logic             rs_done;

    logic [LEN_W-1:0] jump_q, late_ext, early_rem, early_cut, len1_n, len2_n;
    logic             late, early, end1, end2;

    assign run = (state == ST_SYNC) || (state == ST_PH1) || (state == ST_PH2);

    // Phase-error handling: lengthen segment 1 or shorten segment 2.
    always_comb begin
        jump_q    = LEN_W'(sjw_m1) + ONE;
        late_ext  = ((qcnt + ONE) > jump_q) ? jump_q : (qcnt + ONE);
        early_rem = len2 - ONE - qcnt;
        early_cut = (early_rem > jump_q) ? jump_q : early_rem;
        late      = (state == ST_PH1) && fall_edge && !rs_done;
        early     = (state == ST_PH2) && fall_edge && !rs_done;
        len1_n    = late  ? (len1 + late_ext)  : len1;
        len2_n    = early ? (len2 - early_cut) : len2;
        end1      = (state == ST_PH1) && tq_tick && (qcnt == len1_n - ONE);
        end2      = (state == ST_PH2) && tq_tick && (qcnt == len2_n - ONE);
    end

    always_comb begin
        state_n = state;
        if (init_mode) begin
            state_n = ST_HALT;
        end else begin
            unique case (state)
                ST_HALT: state_n = ST_HUNT;
                ST_HUNT: if (fall_edge) state_n = ST_SYNC;
                ST_SYNC: if (tq_tick)   state_n = ST_PH1;
                ST_PH1:  if (end1)      state_n = ST_PH2;
                ST_PH2:  if (end2)      state_n = ST_SYNC;
                default: state_n = ST_HALT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HALT;
        else
            state <= state_n;
    end

    // Quantum counter, effective segment lengths and resync lock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt    <= '0;
            len1    <= '0;
            len2    <= '0;
            rs_done <= 1'b1;
        end else if (init_mode) begin
            qcnt    <= '0;
            rs_done <= 1'b1;
        end else begin
            unique case (state)
                ST_HALT, ST_HUNT: begin
                    qcnt    <= '0;
                    rs_done <= 1'b1;
                end
                ST_SYNC: begin
                    if (tq_tick) begin
                        qcnt <= '0;
                        len1 <= LEN_W'(seg1_m1) + ONE;
                        len2 <= LEN_W'(seg2_m1) + ONE;
                    end
                end
                ST_PH1: begin
                    len1 <= len1_n;
                    if (late) rs_done <= 1'b1;
                    if (end1)         qcnt <= '0;
                    else if (tq_tick) qcnt <= qcnt + ONE;
                end
                ST_PH2: begin
                    len2 <= len2_n;
                    if (early) rs_done <= 1'b1;
                    if (end2) begin
                        qcnt    <= '0;
                        rs_done <= 1'b0;
                    end else if (tq_tick) begin
                        qcnt <= qcnt + ONE;
                    end
                end
                default: qcnt <= '0;
            endcase
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            tx_stb     <= 1'b0;
            rx_bit     <= 1'b1;
        end else begin
            sample_stb <= end1 && !init_mode;
            tx_stb     <= end2 && !init_mode;
            if (end1 && !init_mode) rx_bit <= bus_val;
        end
    end

    assert_strobe_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_stb));

    assert_halt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_mode |=> (!sample_stb && !tx_stb));

    assert_ph1_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH1) |-> ((len1 <= LEN_W'(seg1_m1) + LEN_W'(sjw_m1) + ONE + ONE)
                               && (qcnt < len1)));

    assert_ph2_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH2) |-> ((len2 >= ONE) && (qcnt < len2)));

    assert_sample_enters_ph2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> ((state == ST_PH2) && (qcnt == '0)));

    assert_tx_enters_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> (state == ST_SYNC));

endmodule

// File: rtl/cbt_bit_timer.sv
module cbt_bit_timer #(
    parameter int BRP_W  = 6,
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int SJW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_mode,
    input  logic              rx_in,
    input  logic [BRP_W-1:0]  cfg_brp_m1,
    input  logic [SEG1_W-1:0] cfg_seg1_m1,
    input  logic [SEG2_W-1:0] cfg_seg2_m1,
    input  logic [SJW_W-1:0]  cfg_sjw_m1,
    input  logic              cfg_triple,
    output logic              sample_stb,
    output logic              rx_bit,
    output logic              tx_stb
);
    logic [BRP_W-1:0]  brp_s;
    logic [SEG1_W-1:0] seg1_s;
    logic [SEG2_W-1:0] seg2_s;
    logic [SJW_W-1:0]  sjw_s;
    logic              triple_s;
    logic              rx_prev, fall_edge, tq_tick, run, bus_val;

    // Shadow configuration, writable only in the hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brp_s    <= '0;
            seg1_s   <= '0;
            seg2_s   <= '0;
            sjw_s    <= '0;
            triple_s <= 1'b0;
        end else if (init_mode) begin
            brp_s    <= cfg_brp_m1;
            seg1_s   <= cfg_seg1_m1;
            seg2_s   <= cfg_seg2_m1;
            sjw_s    <= cfg_sjw_m1;
            triple_s <= cfg_triple;
        end
    end

    // Recessive-to-dominant edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_prev <= 1'b1;
        else        rx_prev <= rx_in;
    end
    assign fall_edge = rx_prev & ~rx_in;

    cbt_tq_prescaler #(.BRP_W(BRP_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .brp_m1  (brp_s),
        .tq_tick (tq_tick)
    );

    cbt_bit_sampler u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_tick   (tq_tick),
        .rx_in     (rx_in),
        .triple_en (triple_s),
        .bus_val   (bus_val)
    );

    cbt_seg_fsm #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_mode  (init_mode),
        .tq_tick    (tq_tick),
        .fall_edge  (fall_edge),
        .bus_val    (bus_val),
        .seg1_m1    (seg1_s),
        .seg2_m1    (seg2_s),
        .sjw_m1     (sjw_s),
        .run        (run),
        .sample_stb (sample_stb),
        .rx_bit     (rx_bit),
        .tx_stb     (tx_stb)
    );

    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_mode |=> $stable({brp_s, seg1_s, seg2_s, sjw_s, triple_s}));

endmodule

// File: tb/cbt_bit_timer_tb_top.sv
`timescale 1ns/1ps
module cbt_bit_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n, init_mode, rx_in, cfg_triple;
    logic [5:0] cfg_brp_m1;
    logic [3:0] cfg_seg1_m1;
    logic [2:0] cfg_seg2_m1;
    logic [1:0] cfg_sjw_m1;
    logic       sample_stb, rx_bit, tx_stb;

    always #2 clk = ~clk;

    cbt_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .rx_in(rx_in),
        .cfg_brp_m1(cfg_brp_m1), .cfg_seg1_m1(cfg_seg1_m1),
        .cfg_seg2_m1(cfg_seg2_m1), .cfg_sjw_m1(cfg_sjw_m1),
        .cfg_triple(cfg_triple), .sample_stb(sample_stb),
        .rx_bit(rx_bit), .tx_stb(tx_stb)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int samp_at[8];
    int tx_at[8];
    int bit_at[8];
    int ns, nt;

    typedef struct packed {
        logic [5:0] brp;
        logic [3:0] s1;
        logic [2:0] s2;
        logic [1:0] sjw;
        logic       tri_en;
        logic [7:0] samp;
        logic [7:0] tx;
    } vec_t;

    localparam int NVEC = 6;
    // Expected: sample = B*(1+S1), tx = B*(1+S1+S2), fields stored minus one.
    localparam vec_t VTAB [NVEC] = '{
        '{6'd0, 4'd0,  3'd0, 2'd0, 1'b0, 8'd2,  8'd3},
        '{6'd1, 4'd3,  3'd2, 2'd1, 1'b0, 8'd10, 8'd16},
        '{6'd2, 4'd15, 3'd7, 2'd3, 1'b0, 8'd51, 8'd75},
        '{6'd3, 4'd5,  3'd6, 2'd0, 1'b0, 8'd28, 8'd56},
        '{6'd0, 4'd2,  3'd1, 2'd0, 1'b1, 8'd4,  8'd6},
        '{6'd5, 4'd1,  3'd0, 2'd2, 1'b0, 8'd18, 8'd24}
    };

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input int brp, input int s1, input int s2, input int sjw, input bit tr);
        @(negedge clk);
        init_mode   = 1'b1;
        rx_in       = 1'b1;
        cfg_brp_m1  = 6'(brp);
        cfg_seg1_m1 = 4'(s1);
        cfg_seg2_m1 = 3'(s2);
        cfg_sjw_m1  = 2'(sjw);
        cfg_triple  = tr;
        repeat (3) @(negedge clk);
        init_mode = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Bit k of pat is the line value in clock k; clock 0 holds the hard-sync edge.
    task automatic run_pattern(input logic [127:0] pat, input int len);
        ns = 0;
        nt = 0;
        for (int i = 0; i < 8; i++) begin
            samp_at[i] = -1; tx_at[i] = -1; bit_at[i] = -1;
        end
        for (int k = 0; k < len; k++) begin
            rx_in = pat[k];
            @(posedge clk);
            @(negedge clk);
            if (sample_stb) begin
                if (ns < 8) begin samp_at[ns] = k; bit_at[ns] = int'(rx_bit); end
                ns++;
            end
            if (tx_stb) begin
                if (nt < 8) tx_at[nt] = k;
                nt++;
            end
        end
    endtask

    function automatic logic [127:0] pat_hi(input int rise, input int fall);
        logic [127:0] v;
        for (int k = 0; k < 128; k++) v[k] = (k >= rise) && (k < fall);
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] p;
        rst_n = 1'b0; init_mode = 1'b1; rx_in = 1'b1; cfg_triple = 1'b0;
        cfg_brp_m1 = '0; cfg_seg1_m1 = '0; cfg_seg2_m1 = '0; cfg_sjw_m1 = '0;
        repeat (3) @(negedge clk);
        check("R1 sample_stb in reset", int'(sample_stb), 0);
        check("R1 tx_stb in reset", int'(tx_stb), 0);
        check("R1 rx_bit in reset", int'(rx_bit), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rx_bit after reset", int'(rx_bit), 1);

        // Vector table: R4 R5 R6 R7, one-cycle pulses.
        for (int v = 0; v < NVEC; v++) begin
            setup(int'(VTAB[v].brp), int'(VTAB[v].s1), int'(VTAB[v].s2),
                  int'(VTAB[v].sjw), VTAB[v].tri_en);
            run_pattern('0, int'(VTAB[v].tx) + 2);
            check("R5 sample index", samp_at[0], int'(VTAB[v].samp));
            check("R6 tx index", tx_at[0], int'(VTAB[v].tx));
            check("R5 one sample pulse", ns, 1);
            check("R6 one tx pulse", nt, 1);
            check("R7 sampled dominant", bit_at[0], 0);
        end

        // R2 hold: edges while init_mode is high give no strobes.
        @(negedge clk); init_mode = 1'b1; rx_in = 1'b1;
        repeat (2) @(negedge clk);
        run_pattern('0, 40);
        check("R2 no sample in hold", ns, 0);
        check("R2 no tx in hold", nt, 0);

        // R3: no timing before the falling edge.
        setup(0, 3, 2, 1, 0);
        run_pattern({128{1'b1}}, 30);
        check("R3 idle until edge", ns + nt, 0);

        // R2: config changes outside the hold are ignored.
        setup(0, 3, 2, 1, 0);
        cfg_brp_m1 = 6'd3; cfg_seg1_m1 = 4'd15; cfg_seg2_m1 = 3'd7; cfg_triple = 1'b1;
        run_pattern('0, 10);
        check("R2 cfg ignored sample", samp_at[0], 5);
        check("R2 cfg ignored tx", tx_at[0], 8);

        // Resync cases, B=1, S1=4, S2=3. Nominal: samples 5,13,21 ; tx 8,16.
        setup(0, 3, 2, 1, 0);
        run_pattern(pat_hi(2, 11), 20);
        check("R7 first bit recessive", bit_at[0], 1);
        check("R9 late edge sample", samp_at[1], 15);
        check("R9 late edge tx", tx_at[1], 18);

        setup(0, 3, 2, 1, 0);
        run_pattern(pat_hi(2, 12), 20);
        check("R9 jump width clamp 2", samp_at[1], 15);

        setup(0, 3, 2, 3, 0);
        run_pattern(pat_hi(2, 12), 20);
        check("R9 jump width 4", samp_at[1], 16);

        setup(0, 3, 2, 1, 0);
        run_pattern(pat_hi(2, 14), 24);
        check("R7 second bit recessive", bit_at[1], 1);
        check("R10 early edge tx sjw2", tx_at[1], 14);
        check("R10 early edge next sample sjw2", samp_at[2], 19);

        setup(0, 3, 2, 0, 0);
        run_pattern(pat_hi(2, 14), 24);
        check("R10 early edge tx sjw1", tx_at[1], 15);
        check("R10 early edge next sample sjw1", samp_at[2], 20);

        setup(0, 3, 2, 1, 0);
        p = pat_hi(2, 11); p[12] = 1'b1;
        run_pattern(p, 20);
        check("R11 one resync per bit", samp_at[1], 15);

        setup(0, 3, 2, 1, 0);
        run_pattern(pat_hi(2, 9), 20);
        check("R11 edge in sync ignored", samp_at[1], 13);
        check("R11 edge in sync tx", tx_at[1], 16);

        setup(0, 3, 2, 1, 0);
        run_pattern(pat_hi(11, 128), 20);
        check("R11 rising edge ignored", samp_at[1], 13);
        check("R7 rising then sampled", bit_at[1], 1);

        setup(0, 3, 2, 1, 0);
        run_pattern(pat_hi(2, 13), 20);
        check("R12 edge on sample tick", samp_at[1], 15);

        // Triple sampling, B=1, S1=4, S2=2, sample at clock 5.
        setup(0, 3, 1, 0, 1);
        p = '0; p[5] = 1'b1;
        run_pattern(p, 8);
        check("R8 spike rejected", bit_at[0], 0);

        setup(0, 3, 1, 0, 0);
        run_pattern(p, 8);
        check("R7 spike seen single", bit_at[0], 1);

        setup(0, 3, 1, 0, 1);
        p = '0; p[3] = 1'b1; p[5] = 1'b1;
        run_pattern(p, 8);
        check("R8 two of three", bit_at[0], 1);
        check("R13 sample index triple", samp_at[0], 5);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule